// File: doc/BRIEF.md
# Power-Mode Clock Enable Controller

This block sets the run/stop state of sixteen clock domains for four power modes: active, core sleep, system sleep and hibernate. Software first stores a mode request, then pulses a sleep-entry strobe that stands for the processor executing its sleep instruction. The block switches to the requested mode on the next clock edge. A qualified wake pulse switches it back to active.

Each domain's enable comes from a fixed per-mode policy. The policy is one of: forced on, forced off, following a software enable bit, following an automatic request from the domain's own block, or following either of those two. All enables are combinational functions of the mode register and the current inputs. This lets them change in the same cycle as the mode.

In hibernate, every clock stops, including the interrupt-controller clock. Only the wake inputs selected by a parameter mask can end hibernate. The block also drives the memory retention controls for hibernate. The lower half of the first SRAM is always kept. The upper half is kept when a configuration input is set. The second SRAM and the USB buffer RAM are never kept.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, `mode_o` reads 0 (active), all enables follow the active policy, and the stored request is 1 (core sleep).
- R2: The mode changes from active only when `sleep_entry` is high at a clock edge. At that edge the mode becomes the request stored before that edge. Until that edge, all enables keep the active policy. `mode_o` codes the mode as 0 = active, 1 = core sleep, 2 = system sleep, 3 = hibernate. A stored request of 0 leaves the block in active.
- R3: In core sleep, `clk_en[1]` (core clock) is 0. Bits 0, 2, 3 and 4 (interrupt controller, system bus, counter-timer bus, peripheral bus) are 1. All other bits behave as in active.
- R4: In system sleep, bits 1, 2, 4 and 5 to 12 are 0. Bit 0 is 1. Bit 3 follows `sw_en[3]`. Bits 13 to 15 follow `sw_en`.
- R5: In active, bits 0 to 4 are 1. Bits 5 to 10 (SPI0, SPI1, SPI host, I2C, UART, I2S) and bits 13 to 15 (auxiliary, converter, counter clock) follow `sw_en`. Bit 11 (USB PHY) is `sw_en[11] | usb_phy_req`. Bit 12 (USB controller) equals `usb_ctl_req`.
- R6: In hibernate, all sixteen bits of `clk_en` are 0.
- R7: In core sleep or system sleep, any high bit of `wake_evt` at a clock edge makes the mode active at that edge. From then on the enables follow the active policy. In active, `wake_evt` has no effect.
- R8: In hibernate, only `wake_evt` bits that are set in `HIB_WAKE_MASK` (default: bits 0 and 1) wake the block. Other wake bits are ignored.
- R9: While the mode is not active, a `req_wr` pulse is ignored. The stored request keeps its value for the next sleep entry.
- R10: In hibernate, `ret_sram0_lo` is 1, `ret_sram0_hi` equals `ret_hi_cfg`, and `ret_sram1` and `ret_usbram` are 0. Outside hibernate, all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Write strobe for the mode request |
| req_mode | input | 2 | Requested sleep mode code |
| sleep_entry | input | 1 | Processor sleep-entry strobe |
| sw_en | input | 16 | Software clock enable bits, one per domain |
| usb_phy_req | input | 1 | Automatic request for the USB PHY clock |
| usb_ctl_req | input | 1 | Automatic request for the USB controller clock |
| wake_evt | input | NUM_WAKE | Wake-up event pulses |
| ret_hi_cfg | input | 1 | Keep upper half of first SRAM in hibernate |
| clk_en | output | 16 | Per-domain clock enables |
| mode_o | output | 2 | Current mode code |
| ret_sram0_lo | output | 1 | Retain lower half of first SRAM |
| ret_sram0_hi | output | 1 | Retain upper half of first SRAM |
| ret_sram1 | output | 1 | Retain second SRAM |
| ret_usbram | output | 1 | Retain USB buffer RAM |

## Verification
The hardest cases to reach are the ones where a stimulus must have no effect while the block is asleep. One is a request write during sleep: it must not be taken, and this can only be seen at the next sleep entry. The other is a wake pulse on a source outside the hibernate mask, which must leave the block in hibernate. The stimulus writes a new request while asleep, wakes, and enters sleep again without a new write, so the kept request shows up on `mode_o`. It then enters hibernate and pulses the unmasked wake lines, alone and together, before a masked line ends it. A reference model compares the mode, all enables and the retention outputs every cycle, while the software enables and the automatic requests change.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int NUM_DOM = 16;

  typedef enum logic [1:0] {
    MODE_ACTIVE   = 2'd0,
    MODE_CORE_SLP = 2'd1,
    MODE_SYS_SLP  = 2'd2,
    MODE_HIBERN   = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    POL_OFF     = 3'd0,
    POL_ON      = 3'd1,
    POL_SW      = 3'd2,
    POL_AUTO    = 3'd3,
    POL_SW_AUTO = 3'd4
  } gate_pol_e;

  // domain indices
  localparam int D_INTC    = 0;
  localparam int D_CORE    = 1;
  localparam int D_SYSBUS  = 2;
  localparam int D_CTBUS   = 3;
  localparam int D_PERBUS  = 4;
  localparam int D_SER_LO  = 5;
  localparam int D_SER_HI  = 10;
  localparam int D_USBPHY  = 11;
  localparam int D_USBCTL  = 12;
  localparam int D_ANA_LO  = 13;

  // per-domain, per-mode gating policy
  function automatic gate_pol_e dom_policy(int dom, pwr_mode_e m);
    gate_pol_e p;
    p = POL_OFF;
    if (m != MODE_HIBERN) begin
      if (dom == D_INTC) begin
        p = POL_ON;
      end else if (dom == D_CORE) begin
        p = (m == MODE_ACTIVE) ? POL_ON : POL_OFF;
      end else if (dom == D_SYSBUS || dom == D_PERBUS) begin
        p = (m == MODE_SYS_SLP) ? POL_OFF : POL_ON;
      end else if (dom == D_CTBUS) begin
        p = (m == MODE_SYS_SLP) ? POL_SW : POL_ON;
      end else if (dom >= D_SER_LO && dom <= D_SER_HI) begin
        p = (m == MODE_SYS_SLP) ? POL_OFF : POL_SW;
      end else if (dom == D_USBPHY) begin
        p = (m == MODE_SYS_SLP) ? POL_OFF : POL_SW_AUTO;
      end else if (dom == D_USBCTL) begin
        p = (m == MODE_SYS_SLP) ? POL_OFF : POL_AUTO;
      end else if (dom >= D_ANA_LO) begin
        p = POL_SW;
      end
    end
    return p;
  endfunction

  function automatic logic apply_policy(gate_pol_e p, logic sw, logic au);
    logic e;
    case (p)
      POL_ON:      e = 1'b1;
      POL_SW:      e = sw;
      POL_AUTO:    e = au;
      POL_SW_AUTO: e = sw | au;
      default:     e = 1'b0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pcg_mode_ctrl.sv
module pcg_mode_ctrl
  import pcg_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter logic [NUM_WAKE-1:0] HIB_WAKE_MASK = 4'b0011
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic [1:0]          req_mode,
  input  logic                sleep_entry,
  input  logic [NUM_WAKE-1:0] wake_evt,
  output pwr_mode_e           mode,
  output pwr_mode_e           req_q
);

  logic in_active;
  logic enter_sleep;
  logic wake_any;
  logic wake_hib;
  logic wake_hit;
  logic req_take;

  assign in_active   = (mode == MODE_ACTIVE);
  assign enter_sleep = in_active & sleep_entry;
  assign req_take    = in_active & req_wr;
  assign wake_any    = |wake_evt;
  assign wake_hib    = |(wake_evt & HIB_WAKE_MASK);
  assign wake_hit    = (mode == MODE_HIBERN) ? wake_hib : (!in_active & wake_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_ACTIVE;
    end else if (enter_sleep) begin
      mode <= req_q;
    end else if (wake_hit) begin
      mode <= MODE_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= MODE_CORE_SLP;
    end else if (req_take) begin
      req_q <= pwr_mode_e'(req_mode);
    end
  end

  // R2: sleep entry moves to the request held before the edge
  a_r2_entry_takes_req: assert property (@(posedge clk) disable iff (!rst_n)
    enter_sleep |=> (mode == $past(req_q)));

  // R2: without entry strobe an active block stays active
  a_r2_no_spurious_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (in_active && !sleep_entry) |=> (mode == MODE_ACTIVE));

  // R7: qualified wake returns to active at the next edge
  a_r7_wake_to_active: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> (mode == MODE_ACTIVE));

  // R8: unmasked wake bits cannot end hibernate
  a_r8_hib_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HIBERN && (wake_evt & HIB_WAKE_MASK) == '0) |=> (mode == MODE_HIBERN));

  // R9: request register frozen while asleep
  a_r9_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ACTIVE) |=> $stable(req_q));

endmodule

// File: rtl/pcg_dom_gate.sv
module pcg_dom_gate
  import pcg_pkg::*;
#(
  parameter int DOM = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pwr_mode_e mode,
  input  logic      sw_bit,
  input  logic      auto_req,
  output logic      en
);

  gate_pol_e pol;

  assign pol = dom_policy(DOM, mode);
  assign en  = apply_policy(pol, sw_bit, auto_req);

  // R6: no clock runs in hibernate
  a_r6_hib_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HIBERN) |-> !en);

  // R5: forced-on policy never yields a stopped clock
  a_r5_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_ON) |-> en);

endmodule

// File: rtl/pcg_retain.sv
module pcg_retain
  import pcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pwr_mode_e mode,
  input  logic      ret_hi_cfg,
  output logic      ret_lo,
  output logic      ret_hi,
  output logic      ret_s1,
  output logic      ret_usb
);

  logic in_hib;

  assign in_hib  = (mode == MODE_HIBERN);
  assign ret_lo  = in_hib;
  assign ret_hi  = in_hib & ret_hi_cfg;
  assign ret_s1  = 1'b0;
  assign ret_usb = 1'b0;

  // R10: upper half retention never without its configuration bit
  a_r10_hi_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    ret_hi |-> (ret_lo && ret_hi_cfg));

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcg_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter logic [NUM_WAKE-1:0] HIB_WAKE_MASK = 4'b0011
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic [1:0]          req_mode,
  input  logic                sleep_entry,
  input  logic [15:0]         sw_en,
  input  logic                usb_phy_req,
  input  logic                usb_ctl_req,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                ret_hi_cfg,
  output logic [15:0]         clk_en,
  output logic [1:0]          mode_o,
  output logic                ret_sram0_lo,
  output logic                ret_sram0_hi,
  output logic                ret_sram1,
  output logic                ret_usbram
);

  pwr_mode_e            mode;
  pwr_mode_e            req_q;
  logic [NUM_DOM-1:0]   auto_vec;
  logic [NUM_DOM-1:0]   en_vec;

  pcg_mode_ctrl #(
    .NUM_WAKE      (NUM_WAKE),
    .HIB_WAKE_MASK (HIB_WAKE_MASK)
  ) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_wr      (req_wr),
    .req_mode    (req_mode),
    .sleep_entry (sleep_entry),
    .wake_evt    (wake_evt),
    .mode        (mode),
    .req_q       (req_q)
  );

  always_comb begin
    auto_vec           = '0;
    auto_vec[D_USBPHY] = usb_phy_req;
    auto_vec[D_USBCTL] = usb_ctl_req;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pcg_dom_gate #(.DOM(d)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .sw_bit   (sw_en[d]),
      .auto_req (auto_vec[d]),
      .en       (en_vec[d])
    );
  end

  pcg_retain u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .ret_hi_cfg (ret_hi_cfg),
    .ret_lo     (ret_sram0_lo),
    .ret_hi     (ret_sram0_hi),
    .ret_s1     (ret_sram1),
    .ret_usb    (ret_usbram)
  );

  assign clk_en = en_vec;
  assign mode_o = mode;

  // R3: interrupt-controller clock runs in every non-hibernate mode
  a_r3_intc_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd3) |-> clk_en[D_INTC]);

  // R3: core clock stopped in both sleep modes
  a_r3_core_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 || mode_o == 2'd2) |-> !clk_en[D_CORE]);

  // R4: system sleep stops bus, peripheral and serial clocks
  a_r4_sys_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (clk_en[12:4] == 9'd0 && !clk_en[D_SYSBUS]));

  // R10: retention only in hibernate
  a_r10_ret_hib_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_sram0_lo || ret_sram0_hi) |-> (mode_o == 2'd3));

endmodule

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic        sleep_entry = 1'b0;
  logic [15:0] sw_en = 16'h0000;
  logic        usb_phy_req = 1'b0;
  logic        usb_ctl_req = 1'b0;
  logic [3:0]  wake_evt = 4'h0;
  logic        ret_hi_cfg = 1'b0;
  logic [15:0] clk_en;
  logic [1:0]  mode_o;
  logic        ret_sram0_lo, ret_sram0_hi, ret_sram1, ret_usbram;

  int checks = 0;
  int failures = 0;
  int m_mode = 0;
  int m_req = 1;
  bit run_cmp = 1'b0;

  always #5 clk = ~clk;

  pwr_clk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_mode(req_mode),
    .sleep_entry(sleep_entry), .sw_en(sw_en), .usb_phy_req(usb_phy_req),
    .usb_ctl_req(usb_ctl_req), .wake_evt(wake_evt), .ret_hi_cfg(ret_hi_cfg),
    .clk_en(clk_en), .mode_o(mode_o), .ret_sram0_lo(ret_sram0_lo),
    .ret_sram0_hi(ret_sram0_hi), .ret_sram1(ret_sram1), .ret_usbram(ret_usbram)
  );

  function automatic logic [15:0] exp_en(int md, logic [15:0] sw, logic pr, logic cr);
    logic [15:0] e;
    case (md)
      0: begin e = 16'h001F | (sw & 16'hE7E0); e[11] = sw[11] | pr; e[12] = cr; end
      1: begin e = 16'h001D | (sw & 16'hE7E0); e[11] = sw[11] | pr; e[12] = cr; end
      2: e = 16'h0001 | (sw & 16'hE008);
      default: e = 16'h0000;
    endcase
    return e;
  endfunction

  function automatic string mode_req(int md);
    case (md)
      0: return "R5";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string rq, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_req = 1;
    end else if (m_mode == 0) begin
      if (sleep_entry) m_mode = m_req;
      if (req_wr) m_req = int'(req_mode);
    end else if (m_mode == 3) begin
      if ((wake_evt & 4'b0011) != 0) m_mode = 0;
    end else if (wake_evt != 0) begin
      m_mode = 0;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R2", int'(mode_o), m_mode, "mode_o");
      chk(mode_req(m_mode), int'(clk_en), int'(exp_en(m_mode, sw_en, usb_phy_req, usb_ctl_req)), "clk_en");
      chk("R10", int'({ret_sram0_lo, ret_sram0_hi, ret_sram1, ret_usbram}),
          (m_mode == 3) ? int'({1'b1, ret_hi_cfg, 2'b00}) : 0, "retention");
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic pulse_entry();
    sleep_entry = 1'b1; tick(1); sleep_entry = 1'b0;
  endtask

  task automatic write_req(logic [1:0] v);
    req_wr = 1'b1; req_mode = v; tick(1); req_wr = 1'b0;
  endtask

  task automatic wake(logic [3:0] w);
    wake_evt = w; tick(1); wake_evt = 4'h0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    sw_en = 16'hA5A5;
    tick(3);
    #1;
    // R1 reset state
    chk("R1", int'(mode_o), 0, "reset mode");
    chk("R1", int'(clk_en), int'(exp_en(0, sw_en, 1'b0, 1'b0)), "reset enables");
    chk("R1", int'(ret_sram0_lo), 0, "reset retention");
    rst_n = 1'b1;
    tick(1);
    run_cmp = 1'b1;

    // R5 active with several enable patterns; R7 wake ignored in active
    sw_en = 16'hFFFF; tick(2);
    sw_en = 16'h0000; usb_phy_req = 1'b1; tick(2);
    usb_ctl_req = 1'b1; usb_phy_req = 1'b0; sw_en = 16'h5A5A; tick(2);
    wake(4'hF);
    #3; chk("R7", int'(mode_o), 0, "wake in active ignored"); #2;

    // R1 default request -> core sleep
    pulse_entry();
    #3; chk("R1", int'(mode_o), 1, "default request core sleep"); #2;
    sw_en = 16'hFFFF; tick(2);
    sw_en = 16'h1234; usb_phy_req = 1'b1; tick(2);
    // R9 write during sleep ignored
    write_req(2'd3);
    tick(1);
    wake(4'b0100);
    #3; chk("R7", int'(mode_o), 0, "wake from core sleep"); #2;
    pulse_entry();
    #3; chk("R9", int'(mode_o), 1, "request kept after sleep write"); #2;
    wake(4'b1000);

    // R4 system sleep
    write_req(2'd2);
    tick(1);
    pulse_entry();
    #3; chk("R4", int'(mode_o), 2, "system sleep entered"); #2;
    sw_en = 16'hFFFF; tick(2);
    sw_en = 16'h0008; tick(2);
    sw_en = 16'hE000; usb_ctl_req = 1'b1; tick(2);
    pulse_entry();
    #3; chk("R2", int'(mode_o), 2, "entry ignored while asleep"); #2;
    wake(4'b0001);
    #3; chk("R7", int'(mode_o), 0, "wake from system sleep"); #2;

    // R6/R8/R10 hibernate, upper half not retained
    write_req(2'd3);
    ret_hi_cfg = 1'b0;
    pulse_entry();
    #3; chk("R10", int'(ret_sram0_hi), 0, "upper half without cfg"); #2;
    sw_en = 16'hFFFF; tick(2);
    wake(4'b0100);
    wake(4'b1000);
    wake(4'b1100);
    #3; chk("R8", int'(mode_o), 3, "unmasked wakes ignored"); #2;
    ret_hi_cfg = 1'b1; tick(1);
    #3; chk("R10", int'(ret_sram0_hi), 1, "upper half with cfg"); #2;
    wake(4'b0010);
    #3; chk("R8", int'(mode_o), 0, "masked wake ends hibernate"); #2;
    pulse_entry();
    wake(4'b0001);
    #3; chk("R8", int'(mode_o), 0, "wake bit0 ends hibernate"); #2;

    // R2 request of active stays active; write and entry together use old value
    write_req(2'd0);
    pulse_entry();
    #3; chk("R2", int'(mode_o), 0, "active request stays active"); #2;
    req_wr = 1'b1; req_mode = 2'd2; sleep_entry = 1'b1; tick(1);
    req_wr = 1'b0; sleep_entry = 1'b0;
    #3; chk("R2", int'(mode_o), 0, "entry uses previous request"); #2;
    pulse_entry();
    #3; chk("R2", int'(mode_o), 2, "entry uses new request"); #2;
    wake(4'b0010);
    tick(3);

    run_cmp = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule